// File: doc/BRIEF.md
# Rate-Trimmed Nanosecond Time-of-Day Counter

This block keeps a 64-bit time-of-day value in nanoseconds for a precision clock. It does not count reference cycles directly. On every enabled reference cycle, a 32-bit phase accumulator adds a programmable addend. Each time that sum carries out of 32 bits, the time value moves forward by a programmable whole-nanosecond step. The addend sets the fraction of reference cycles that produce a step, so software can trim the clock rate in very fine increments. If the addend is set to 2^32 times the nominal frequency divided by the reference frequency, rounded up, and the step is set to one nominal period in nanoseconds, the counter tracks real time.

Software reaches the block through a small word-wide register port. It has a control word that holds the run bit and the step size, an addend word, and the time value split into two 32-bit halves. A read of the low half captures the high half at the same moment, so the two halves form a coherent pair. A write of the low half is only staged. The following write of the high half loads both halves together and restarts the phase accumulator from zero. The addend can be rewritten at any time without disturbing the count or the accumulator phase.

Top module: `ns_time_counter`

## Requirements
- R1: After reset the time value is 0, the phase accumulator is 0, the run bit is 0, the step size is 0, the addend equals parameter ADDEND_RST (default 32'h8000_0000), and the read data is 0.
- R2: While the run bit is 0, the time value and the phase accumulator hold their values and step_pulse stays low, unless a high-half load occurs.
- R3: On each clock edge with the run bit set, the accumulator becomes (accumulator + addend) mod 2^32. If that sum is 2^32 or more, step_pulse is high in that cycle and the time value increases by the step size at the same edge. Otherwise the time value is unchanged.
- R4: An addend of 0 never advances the time. An addend of 32'hFFFF_FFFF starting from a cleared accumulator gives no step on the first enabled edge and a step on every enabled edge after it.
- R5: A read of register 2 (time low) returns bits 31:0 of the time value and, in the same edge, captures bits 63:32 into a shadow. A read of register 3 (time high) returns that shadow, even if the time value has moved since.
- R6: A write to register 2 only stages the low half and leaves the time value unchanged. A write to register 3 sets the time value to {written data, staged low half} at that edge and clears the phase accumulator.
- R7: A write to register 1 (addend) replaces the addend and leaves both the time value and the accumulator phase undisturbed.
- R8: Register 0 (control) keeps the run bit at bit 0 and the step size at bits 15:8. A read of it returns those fields, with all other bits reading 0.
- R9: bus_rdata is registered. It updates at the edge that samples bus_rd and holds its value in every cycle without a read.
- R10: The time value wraps modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 2 | Register select: 0 control, 1 addend, 2 time low, 3 time high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| time_ns | output | 64 | Live time value in nanoseconds |
| step_pulse | output | 1 | High in cycles where the accumulator carries and the time value steps |

## Verification
The assertions assume that software follows the access order: a time-low write comes before the time-high write that loads it, and a time-low read comes before the matching time-high read. The load property checks the staged low half, not a port value. The bench follows that order in every access, issues one strobe per cycle, and changes the run bit only through control writes, so each step can be counted from the programmed addend. The rate vectors and the directed cases for coherence, staging, phase preservation and wrap all start from a high-half load. That load clears the accumulator, so the expected carry sequence can be worked out by hand.

// File: rtl/ns_time_counter_pkg.sv
// Shared register selects and control-word field placement for the
// nanosecond time counter. Field positions are software visible.
package ns_time_counter_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL    = 2'd0,
        SEL_ADDEND  = 2'd1,
        SEL_TIME_LO = 2'd2,
        SEL_TIME_HI = 2'd3
    } reg_sel_e;

    localparam int CTRL_RUN_BIT = 0;
    localparam int CTRL_STEP_LSB = 8;

endpackage

// File: rtl/ntc_phase_acc.sv
// Fractional phase accumulator. On each enabled edge it adds the addend
// to its state and reports the carry out as a step request in the same
// cycle. A clear request forces the state to zero and wins over run.
// Assumes: the addend is stable for the cycle in which it is sampled.
module ntc_phase_acc #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [ACC_W-1:0] addend,
    output logic             step
);

    logic [ACC_W-1:0] phase_q;
    logic [ACC_W:0]   sum;

    // Wide sum whose top bit is the carry out of the accumulator.
    always_comb begin
        sum  = {1'b0, phase_q} + {1'b0, addend};
        step = run && !clr && sum[ACC_W];
    end

    // Phase state: reset, clear on load, advance while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (clr) begin
            phase_q <= '0;
        end else if (run) begin
            phase_q <= sum[ACC_W-1:0];
        end
    end

endmodule

// File: rtl/ntc_time_reg.sv
// Nanosecond time register. A load replaces the whole value. Otherwise a
// step request adds the step size, and the value wraps modulo 2^TIME_W.
// Assumes: load and step come from the same clock domain.
module ntc_time_reg #(
    parameter int TIME_W   = 64,
    parameter int PERIOD_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [TIME_W-1:0]   load_val,
    input  logic                step,
    input  logic [PERIOD_W-1:0] period,
    output logic [TIME_W-1:0]   count
);

    localparam int PAD_W = TIME_W - PERIOD_W;

    logic [TIME_W-1:0] period_ext;

    // Zero-extend the step size to the counter width.
    always_comb period_ext = {{PAD_W{1'b0}}, period};

    // Counter update: load has priority over stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (step) begin
            count <= count + period_ext;
        end
    end

endmodule

// File: rtl/ntc_regs.sv
// Register port of the time counter. It holds the control fields and the
// addend, stages the low half of a time write, builds the load request
// on a high-half write, and serves reads through a registered data path
// with a high-half shadow captured on low-half reads.
// Assumes: at most one access per strobe per cycle, and software orders
// split accesses low half first.
module ntc_regs
    import ns_time_counter_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int PERIOD_W   = 8,
    parameter int TIME_W     = 2 * WORD_W,
    parameter logic [WORD_W-1:0] ADDEND_RST = 32'h8000_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [1:0]          bus_addr,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    input  logic [TIME_W-1:0]   time_now,
    output logic                run_en,
    output logic [PERIOD_W-1:0] period,
    output logic [WORD_W-1:0]   addend,
    output logic [WORD_W-1:0]   lo_hold,
    output logic                load,
    output logic [TIME_W-1:0]   load_val
);

    localparam int HI_PAD_W = WORD_W - PERIOD_W - CTRL_STEP_LSB;
    localparam int MID_W    = CTRL_STEP_LSB - 1;

    reg_sel_e          sel;
    logic [WORD_W-1:0] ctrl_word;
    logic [WORD_W-1:0] hi_shadow;

    // Decode the register select and assemble the control readback.
    always_comb begin
        sel       = reg_sel_e'(bus_addr);
        ctrl_word = {{HI_PAD_W{1'b0}}, period, {MID_W{1'b0}}, run_en};
    end

    // Load request: a high-half write commits both halves together.
    always_comb begin
        load     = bus_wr && (sel == SEL_TIME_HI);
        load_val = {bus_wdata, lo_hold};
    end

    // Writable state: control fields, addend and staged low half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_en  <= 1'b0;
            period  <= '0;
            addend  <= ADDEND_RST;
            lo_hold <= '0;
        end else if (bus_wr) begin
            case (sel)
                SEL_CTRL: begin
                    run_en <= bus_wdata[CTRL_RUN_BIT];
                    period <= bus_wdata[CTRL_STEP_LSB +: PERIOD_W];
                end
                SEL_ADDEND:  addend  <= bus_wdata;
                SEL_TIME_LO: lo_hold <= bus_wdata;
                default: ;
            endcase
        end
    end

    // Registered read path with the high-half shadow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
            hi_shadow <= '0;
        end else if (bus_rd) begin
            case (sel)
                SEL_CTRL:    bus_rdata <= ctrl_word;
                SEL_ADDEND:  bus_rdata <= addend;
                SEL_TIME_LO: begin
                    bus_rdata <= time_now[WORD_W-1:0];
                    hi_shadow <= time_now[TIME_W-1:WORD_W];
                end
                default:     bus_rdata <= hi_shadow;
            endcase
        end
    end

endmodule

// File: rtl/ns_time_counter.sv
// Top of the rate-trimmed nanosecond time counter. It joins the register
// port, the phase accumulator and the time register. The accumulator
// carry steps the time value by the programmed nanosecond step.
// Assumes: one clock domain and a synchronous active-low reset.
module ns_time_counter #(
    parameter int WORD_W   = 32,
    parameter int PERIOD_W = 8,
    parameter logic [WORD_W-1:0] ADDEND_RST = 32'h8000_0000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [1:0]            bus_addr,
    input  logic [WORD_W-1:0]     bus_wdata,
    output logic [WORD_W-1:0]     bus_rdata,
    output logic [2*WORD_W-1:0]   time_ns,
    output logic                  step_pulse
);

    localparam int TIME_W = 2 * WORD_W;

    logic                run_en;
    logic [PERIOD_W-1:0] period;
    logic [WORD_W-1:0]   addend;
    logic [WORD_W-1:0]   lo_hold;
    logic                load;
    logic [TIME_W-1:0]   load_val;

    ntc_regs #(
        .WORD_W     (WORD_W),
        .PERIOD_W   (PERIOD_W),
        .TIME_W     (TIME_W),
        .ADDEND_RST (ADDEND_RST)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .time_now  (time_ns),
        .run_en    (run_en),
        .period    (period),
        .addend    (addend),
        .lo_hold   (lo_hold),
        .load      (load),
        .load_val  (load_val)
    );

    ntc_phase_acc #(
        .ACC_W (WORD_W)
    ) acc_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run_en),
        .clr    (load),
        .addend (addend),
        .step   (step_pulse)
    );

    ntc_time_reg #(
        .TIME_W   (TIME_W),
        .PERIOD_W (PERIOD_W)
    ) time_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .step     (step_pulse),
        .period   (period),
        .count    (time_ns)
    );

endmodule

// File: rtl/ns_time_counter_chk.sv
// Property checker for the time counter, attached through bind. It looks
// at the ports plus the run bit, step size and staged low half.
module ns_time_counter_chk #(
    parameter int WORD_W   = 32,
    parameter int PERIOD_W = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_wr,
    input logic                  bus_rd,
    input logic [1:0]            bus_addr,
    input logic [WORD_W-1:0]     bus_wdata,
    input logic [WORD_W-1:0]     bus_rdata,
    input logic [2*WORD_W-1:0]   time_ns,
    input logic                  step_pulse,
    input logic                  run_en,
    input logic [PERIOD_W-1:0]   period,
    input logic [WORD_W-1:0]     lo_hold
);

    localparam int TIME_W = 2 * WORD_W;

    logic hi_load;
    logic lo_read;
    assign hi_load = bus_wr && (bus_addr == 2'd3);
    assign lo_read = bus_rd && (bus_addr == 2'd2);

    // R2: stopped counter holds its value.
    a_r2_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !hi_load) |=> $stable(time_ns));

    // R2: no step request while stopped.
    a_r2_no_step_off: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |-> !step_pulse);

    // R3: a step adds exactly the step size.
    a_r3_step_adds: assert property (@(posedge clk) disable iff (!rst_n)
        (step_pulse && !hi_load) |=> time_ns ==
            $past(time_ns) + {{(TIME_W-PERIOD_W){1'b0}}, $past(period)});

    // R3: without a carry the time value does not move.
    a_r3_still_without_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_pulse && !hi_load) |=> $stable(time_ns));

    // R6: a high-half write loads the staged pair.
    a_r6_load_pair: assert property (@(posedge clk) disable iff (!rst_n)
        hi_load |=> time_ns == {$past(bus_wdata), $past(lo_hold)});

    // R6: cleared accumulator cannot carry on the first edge after a load.
    a_r6_no_carry_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        hi_load |=> !step_pulse);

    // R5: a low-half read returns the live low half.
    a_r5_lo_read: assert property (@(posedge clk) disable iff (!rst_n)
        lo_read |=> bus_rdata == $past(time_ns[WORD_W-1:0]));

    // R9: read data holds without a read strobe.
    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

endmodule

bind ns_time_counter ns_time_counter_chk #(
    .WORD_W   (WORD_W),
    .PERIOD_W (PERIOD_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .time_ns    (time_ns),
    .step_pulse (step_pulse),
    .run_en     (run_en),
    .period     (period),
    .lo_hold    (lo_hold)
);

// File: tb/ns_time_counter_tb_top.sv
`timescale 1ns/1ps
module ns_time_counter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] time_ns;
    logic        step_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ns_time_counter dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .time_ns    (time_ns),
        .step_pulse (step_pulse)
    );

    typedef struct packed {
        logic [31:0] addend;
        logic [7:0]  step;
        logic [7:0]  edges;
        logic [63:0] expect_ns;
    } vec_t;

    // Rate vectors (R3, R4): each starts from a cleared accumulator.
    localparam vec_t VECS [6] = '{
        '{32'h8000_0000, 8'd5,  8'd10, 64'd25},
        '{32'hFFFF_FFFF, 8'd4,  8'd6,  64'd20},
        '{32'h0000_0000, 8'd7,  8'd8,  64'd0},
        '{32'h4000_0000, 8'd10, 8'd9,  64'd20},
        '{32'hC000_0000, 8'd3,  8'd4,  64'd9},
        '{32'h5555_5556, 8'd8,  8'd6,  64'd16}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the following negedge.
    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic load_time(input logic [63:0] v);
        bus_write(2'd2, v[31:0]);
        bus_write(2'd3, v[63:32]);
    endtask

    // Run for exactly n enabled edges with the given step size.
    task automatic run_edges(input logic [7:0] step, input int n);
        bus_write(2'd0, {16'h0, step, 8'h01});
        repeat (n - 1) @(negedge clk);
        bus_write(2'd0, {16'h0, step, 8'h00});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] lo, hi, r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 time", time_ns, 64'd0);
        check("R1 step", {63'd0, step_pulse}, 64'd0);
        check("R1 rdata", {32'd0, bus_rdata}, 64'd0);
        bus_read(2'd0, r);
        check("R1 ctrl", {32'd0, r}, 64'd0);
        bus_read(2'd1, r);
        check("R1 addend", {32'd0, r}, 64'h8000_0000);

        // R3 R4: table of rate vectors
        foreach (VECS[i]) begin
            load_time(64'd0);
            bus_write(2'd1, VECS[i].addend);
            run_edges(VECS[i].step, int'(VECS[i].edges));
            bus_read(2'd2, lo);
            bus_read(2'd3, hi);
            check($sformatf("R3 vector %0d", i), {hi, lo}, VECS[i].expect_ns);
        end

        // R2: stopped counter ignores a fast addend
        load_time(64'd100);
        bus_write(2'd1, 32'hFFFF_FFFF);
        repeat (6) @(negedge clk);
        check("R2 time held", time_ns, 64'd100);
        check("R2 no step", {63'd0, step_pulse}, 64'd0);

        // R8: control field readback
        bus_write(2'd0, 32'hFFFF_FF00);
        bus_read(2'd0, r);
        check("R8 ctrl fields", {32'd0, r}, 64'h0000_FF00);
        repeat (3) @(negedge clk);
        check("R8 run bit clear", time_ns, 64'd100);

        // R9: read data holds without strobe, also across writes
        bus_write(2'd1, 32'hFFFF_FFFF);
        repeat (3) @(negedge clk);
        check("R9 rdata hold", {32'd0, bus_rdata}, 64'h0000_FF00);

        // R5: coherent split read across a high-half rollover
        load_time(64'h0000_0000_FFFF_FFF0);
        bus_write(2'd0, 32'h0000_0801);
        bus_read(2'd2, lo);
        check("R5 low read", {32'd0, lo}, 64'hFFFF_FFF0);
        repeat (10) @(negedge clk);
        check("R5 live time", time_ns, 64'h0000_0001_0000_0040);
        bus_read(2'd3, hi);
        check("R5 shadow high", {32'd0, hi}, 64'd0);
        bus_write(2'd0, 32'h0000_0800);
        check("R5 stopped time", time_ns, 64'h0000_0001_0000_0050);
        bus_read(2'd2, lo);
        bus_read(2'd3, hi);
        check("R5 coherent pair", {hi, lo}, 64'h0000_0001_0000_0050);

        // R7: addend rewrite keeps count and phase
        load_time(64'd0);
        bus_write(2'd1, 32'h8000_0000);
        run_edges(8'd6, 1);
        bus_write(2'd1, 32'hC000_0000);
        check("R7 count kept", time_ns, 64'd0);
        run_edges(8'd6, 1);
        check("R7 phase kept", time_ns, 64'd6);

        // R6: staged low half, commit on high write, accumulator cleared
        bus_write(2'd2, 32'h1234_5678);
        check("R6 low staged only", time_ns, 64'd6);
        bus_write(2'd3, 32'h0000_000A);
        check("R6 pair loaded", time_ns, 64'h0000_000A_1234_5678);
        run_edges(8'd6, 1);
        check("R6 phase cleared", time_ns, 64'h0000_000A_1234_5678);

        // R10: wrap at 2^64
        load_time(64'hFFFF_FFFF_FFFF_FFFC);
        bus_write(2'd1, 32'hFFFF_FFFF);
        run_edges(8'd4, 2);
        check("R10 wrap", time_ns, 64'd0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule